// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer that sits on a simple write/read register bus and runs from a single slow count clock. Software arms it with a two-word key sequence and disarms it with a different two-word sequence. Once armed, an up-counter starts at a programmed load value and advances on every prescaled tick. If the counter passes all ones, the block raises a reset request for one cycle and starts again from the load value. Software keeps the system alive by writing the trigger register with a value that differs from the one written before, which reloads the counter.

Every bus write is posted. The word is held for a fixed number of count-clock cycles before it takes effect, and while it is held the register's own pending flag reads as set. Four small posting engines, one for each writable register, each run the states IDLE and WAIT. The IDLE to WAIT transition is taken on an accepted write. The WAIT to IDLE transition is taken on the commit cycle. The key sequencer has four states. STOPPED goes to START_HALF on the first start word. START_HALF goes to RUNNING on the second start word and falls back to STOPPED on any other word. RUNNING goes to STOP_HALF on the first stop word. STOP_HALF goes to STOPPED on the second stop word and returns to RUNNING on any other word. The counter has two states. HALTED goes to COUNTING on the start transition, and COUNTING goes to HALTED on the stop transition.

Top module: `kwdt_top`

## Requirements
- R1: The register map is control at address 0 (bit 0 prescaler enable, bits 3:1 prescale exponent), load at 1, trigger at 2, key at 3 (reads back the running flag in bit 0), pending at 4 and counter at 5 (read only). After reset the watchdog is stopped, control, load, trigger and counter read zero, all pending bits are clear, and rst_req is low.
- R2: A committed key word 0x0000BBBB followed by a committed 0x00004444 starts the watchdog. On the start commit the counter is loaded from the load register.
- R3: A committed 0x0000AAAA followed by a committed 0x00005555 stops the watchdog. A stopped counter holds its value and never requests a reset.
- R4: After the first word of either pair, any other committed key word abandons the pair and the running state stays unchanged. A lone second word does nothing.
- R5: While running, the counter advances by one every cycle when the prescaler is disabled, and every 2^exponent cycles when it is enabled.
- R6: When a tick finds the counter at all ones, rst_req is high for exactly one cycle, the counter is reloaded from the load register, and counting continues.
- R7: A committed trigger value that differs from the previous trigger value reloads the counter and restarts the prescaler. A value equal to the previous one does not reload.
- R8: The pending register has bit 0 for control, bit 1 for load, bit 2 for trigger and bit 3 for key. A write sets its bit for 2 cycles after the sampling edge, and the register takes the new value on the edge that clears the bit.
- R9: A write to a register whose pending bit is set at the sampling edge is dropped.
- R10: Committed writes to control and load have no effect while the watchdog is running. Their pending bits still cycle.
- R11: When a trigger reload and an overflowing tick fall on the same edge, the reload wins and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, also used for the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A trigger reload and a counter overflow can land on the same edge, because the posting delay puts the trigger's effect two cycles after its write. The bench loads a value just below all ones with the prescaler off and polls the counter. It issues the trigger write at the moment its commit will coincide with the overflowing tick. It then expects the counter to equal the load value on the next read and rst_req to stay low throughout.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    // register addresses
    localparam int A_CTRL  = 0;
    localparam int A_LOAD  = 1;
    localparam int A_TRIG  = 2;
    localparam int A_KEY   = 3;
    localparam int A_PEND  = 4;
    localparam int A_COUNT = 5;

    // number of registers with a posted-write engine
    localparam int N_POSTED = 4;

    // key words
    localparam logic [31:0] KEY_START_1 = 32'h0000_BBBB;
    localparam logic [31:0] KEY_START_2 = 32'h0000_4444;
    localparam logic [31:0] KEY_STOP_1  = 32'h0000_AAAA;
    localparam logic [31:0] KEY_STOP_2  = 32'h0000_5555;

    typedef enum logic [1:0] {
        KS_STOPPED,
        KS_START_HALF,
        KS_RUNNING,
        KS_STOP_HALF
    } key_state_e;

    typedef enum logic {
        PS_IDLE,
        PS_WAIT
    } post_state_e;

    typedef enum logic {
        CS_HALTED,
        CS_COUNTING
    } cnt_state_e;

endpackage

// File: rtl/kwdt_post.sv
module kwdt_post
    import kwdt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int POST_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pend_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int DLY_W = (POST_DLY > 1) ? $clog2(POST_DLY) : 1;
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(POST_DLY - 1);

    post_state_e       st_q;
    logic [DLY_W-1:0]  dly_q;
    logic [DATA_W-1:0] hold_q;

    // state register: a write is only taken in IDLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PS_IDLE;
            dly_q  <= '0;
            hold_q <= '0;
        end else begin
            unique case (st_q)
                PS_IDLE: begin
                    if (wr_i) begin
                        st_q   <= PS_WAIT;
                        dly_q  <= '0;
                        hold_q <= data_i;
                    end
                end
                PS_WAIT: begin
                    if (dly_q == DLY_LAST) begin
                        st_q <= PS_IDLE;
                    end else begin
                        dly_q <= dly_q + 1'b1;
                    end
                end
                default: st_q <= PS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pend_o   = (st_q == PS_WAIT);
        commit_o = (st_q == PS_WAIT) && (dly_q == DLY_LAST);
        data_o   = hold_q;
    end

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !pend_o)
        else $error("pending bit did not clear after commit");

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !pend_o) |=> pend_o)
        else $error("pending bit not set after accepted write");

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && pend_o) |=> $stable(hold_q))
        else $error("write accepted while pending");

endmodule

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
    import kwdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] key_i,
    output logic              running_o,
    output logic              start_o,
    output logic              stop_o
);

    key_state_e st_q, st_d;

    logic is_start1, is_start2, is_stop1, is_stop2;

    always_comb begin
        is_start1 = (key_i == DATA_W'(KEY_START_1));
        is_start2 = (key_i == DATA_W'(KEY_START_2));
        is_stop1  = (key_i == DATA_W'(KEY_STOP_1));
        is_stop2  = (key_i == DATA_W'(KEY_STOP_2));
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            unique case (st_q)
                KS_STOPPED:    st_d = is_start1 ? KS_START_HALF : KS_STOPPED;
                KS_START_HALF: st_d = is_start2 ? KS_RUNNING    : KS_STOPPED;
                KS_RUNNING:    st_d = is_stop1  ? KS_STOP_HALF  : KS_RUNNING;
                KS_STOP_HALF:  st_d = is_stop2  ? KS_STOPPED    : KS_RUNNING;
                default:       st_d = KS_STOPPED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= KS_STOPPED;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs
    always_comb begin
        running_o = (st_q == KS_RUNNING) || (st_q == KS_STOP_HALF);
        start_o   = commit_i && (st_q == KS_START_HALF) && is_start2;
        stop_o    = commit_i && (st_q == KS_STOP_HALF) && is_stop2;
    end

    // R4
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(running_o))
        else $error("running state changed without a key commit");

    // R2
    start_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> running_o)
        else $error("start sequence did not start");

    // R3
    stop_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !running_o)
        else $error("stop sequence did not stop");

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             reload_i,
    input  logic             pre_en_i,
    input  logic [PTV_W-1:0] ptv_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             rst_req_o
);

    localparam int PS_W = (1 << PTV_W) - 1;
    localparam logic [PS_W-1:0] PS_ONES = '1;

    cnt_state_e      st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PS_W-1:0]  ps_q;
    logic [PS_W-1:0]  ps_lim;
    logic             tick;
    logic             req_q;

    always_comb begin
        ps_lim = pre_en_i ? (PS_ONES >> (PS_W - int'(ptv_i))) : '0;
        tick   = (ps_q == ps_lim);
    end

    // state register, counter and prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CS_HALTED;
            cnt_q <= '0;
            ps_q  <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            unique case (st_q)
                CS_HALTED: begin
                    if (start_i) begin
                        st_q  <= CS_COUNTING;
                        cnt_q <= load_i;
                        ps_q  <= '0;
                    end else if (reload_i) begin
                        cnt_q <= load_i;
                        ps_q  <= '0;
                    end
                end
                CS_COUNTING: begin
                    if (stop_i) begin
                        st_q <= CS_HALTED;
                    end else if (reload_i) begin
                        cnt_q <= load_i;
                        ps_q  <= '0;
                    end else if (tick) begin
                        ps_q <= '0;
                        if (cnt_q == '1) begin
                            cnt_q <= load_i;
                            req_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else begin
                        ps_q <= ps_q + 1'b1;
                    end
                end
                default: st_q <= CS_HALTED;
            endcase
        end
    end

    // outputs
    always_comb begin
        count_o   = cnt_q;
        rst_req_o = req_q;
    end

    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o)
        else $error("reset request longer than one cycle");

    // R6
    req_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (count_o == load_i))
        else $error("counter not reloaded on overflow");

    // R11
    trig_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> !rst_req_o)
        else $error("overflow raised on a reload edge");

    // R3
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_HALTED && !start_i && !reload_i) |=> ($stable(count_o) && !rst_req_o))
        else $error("halted counter moved");

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int PTV_W    = 3,
    parameter int POST_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req
);

    logic [N_POSTED-1:0] wr_sel;
    logic [N_POSTED-1:0] pend;
    logic [N_POSTED-1:0] commit;
    logic [DATA_W-1:0]   post_data [N_POSTED];

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] trig_q;
    logic [DATA_W-1:0] count;
    logic              running;
    logic              start_p;
    logic              stop_p;
    logic              reload;

    for (genvar g = 0; g < N_POSTED; g++) begin : g_post
        assign wr_sel[g] = wr_en && (wr_addr == ADDR_W'(g));

        kwdt_post #(
            .DATA_W   (DATA_W),
            .POST_DLY (POST_DLY)
        ) u_post (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (wr_sel[g]),
            .data_i   (wr_data),
            .pend_o   (pend[g]),
            .commit_o (commit[g]),
            .data_o   (post_data[g])
        );
    end

    // committed register storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            trig_q <= '0;
        end else begin
            if (commit[A_CTRL] && !running) ctrl_q <= post_data[A_CTRL];
            if (commit[A_LOAD] && !running) load_q <= post_data[A_LOAD];
            if (commit[A_TRIG])             trig_q <= post_data[A_TRIG];
        end
    end

    assign reload = commit[A_TRIG] && (post_data[A_TRIG] != trig_q);

    kwdt_keyseq #(
        .DATA_W (DATA_W)
    ) u_keyseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit[A_KEY]),
        .key_i     (post_data[A_KEY]),
        .running_o (running),
        .start_o   (start_p),
        .stop_o    (stop_p)
    );

    kwdt_counter #(
        .CNT_W (DATA_W),
        .PTV_W (PTV_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_p),
        .stop_i    (stop_p),
        .reload_i  (reload),
        .pre_en_i  (ctrl_q[0]),
        .ptv_i     (ctrl_q[PTV_W:1]),
        .load_i    (load_q),
        .count_o   (count),
        .rst_req_o (rst_req)
    );

    // read mux
    always_comb begin
        case (int'(rd_addr))
            A_CTRL:  rd_data = ctrl_q;
            A_LOAD:  rd_data = load_q;
            A_TRIG:  rd_data = trig_q;
            A_KEY:   rd_data = DATA_W'(running);
            A_PEND:  rd_data = DATA_W'(pend);
            A_COUNT: rd_data = count;
            default: rd_data = '0;
        endcase
    end

    // R10
    ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(ctrl_q))
        else $error("control changed while running");

    // R10
    load_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(load_q))
        else $error("load changed while running");

endmodule

// File: tb/kwdt_top_tb.sv
`timescale 1ns/1ps
module kwdt_top_tb_top;

    localparam int DW = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rst_req;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] trig_val = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kwdt_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rst_req (rst_req)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [DW-1:0] d);
        rd_addr = AW'(a);
        #0.5;
        d = rd_data;
    endtask

    task automatic wait_idle();
        logic [DW-1:0] p;
        for (int i = 0; i < 10; i++) begin
            bus_rd(4, p);
            if (p == '0) break;
            @(negedge clk);
        end
    endtask

    task automatic key_pair(input logic [DW-1:0] a, input logic [DW-1:0] b);
        bus_wr(3, a); wait_idle();
        bus_wr(3, b); wait_idle();
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        for (int a = 0; a < 6; a++) begin
            bus_rd(a, v);
            chk("R1", v, '0, $sformatf("reset value addr %0d", a));
        end
        chk("R1", DW'(rst_req), '0, "rst_req after reset");
    endtask

    task automatic t_posting();
        logic [DW-1:0] v;
        bus_wr(1, 32'h55);
        bus_rd(4, v); chk("R8", v, 32'h2, "pending load cycle 1");
        bus_rd(1, v); chk("R8", v, 32'h0, "load not yet updated 1");
        @(negedge clk);
        bus_rd(4, v); chk("R8", v, 32'h2, "pending load cycle 2");
        bus_rd(1, v); chk("R8", v, 32'h0, "load not yet updated 2");
        @(negedge clk);
        bus_rd(4, v); chk("R8", v, 32'h0, "pending clear");
        bus_rd(1, v); chk("R8", v, 32'h55, "load updated");
        bus_wr(0, 32'h3);
        bus_rd(4, v); chk("R8", v, 32'h1, "pending bit for control");
        wait_idle();
        bus_wr(0, 32'h0); wait_idle();
        // R9: second write falls on a pending edge
        bus_wr(1, 32'h100);
        bus_wr(1, 32'h200);
        wait_idle();
        bus_rd(1, v); chk("R9", v, 32'h100, "busy write dropped");
    endtask

    task automatic t_start();
        logic [DW-1:0] v;
        key_pair(32'h0000_BBBB, 32'h0000_4444);
        bus_rd(3, v); chk("R2", v, 32'h1, "running after start pair");
        bus_rd(5, v); chk("R2", DW'(v >= 32'h100 && v < 32'h108), 32'h1, "counter loaded on start");
    endtask

    task automatic t_rate_plain();
        logic [DW-1:0] c0, c1;
        bus_rd(5, c0);
        repeat (10) @(negedge clk);
        bus_rd(5, c1);
        chk("R5", c1 - c0, 32'd10, "unscaled rate");
    endtask

    task automatic t_frozen();
        logic [DW-1:0] v;
        bus_wr(0, 32'h5);
        bus_rd(4, v); chk("R10", v, 32'h1, "control pending cycles while running");
        wait_idle();
        bus_rd(0, v); chk("R10", v, 32'h0, "control unchanged while running");
        bus_wr(1, 32'h999); wait_idle();
        bus_rd(1, v); chk("R10", v, 32'h100, "load unchanged while running");
    endtask

    task automatic t_trigger();
        logic [DW-1:0] v, c0;
        repeat (20) @(negedge clk);
        trig_val = ~trig_val;
        bus_wr(2, trig_val); wait_idle();
        bus_rd(5, v); chk("R7", DW'(v >= 32'h100 && v < 32'h108), 32'h1, "new trigger reloads");
        repeat (20) @(negedge clk);
        bus_rd(5, c0);
        bus_wr(2, trig_val); wait_idle();
        bus_rd(5, v); chk("R7", DW'(v > c0), 32'h1, "equal trigger ignored");
    endtask

    task automatic t_bad_key_running();
        logic [DW-1:0] v;
        bus_wr(3, 32'h0000_AAAA); wait_idle();
        bus_wr(3, 32'h0000_0000); wait_idle();
        bus_wr(3, 32'h0000_5555); wait_idle();
        bus_rd(3, v); chk("R4", v, 32'h1, "broken stop pair keeps running");
    endtask

    task automatic t_stop();
        logic [DW-1:0] v, c0, c1;
        key_pair(32'h0000_AAAA, 32'h0000_5555);
        bus_rd(3, v); chk("R3", v, 32'h0, "stopped after stop pair");
        bus_rd(5, c0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rst_req) chk("R3", 32'h1, 32'h0, "rst_req while stopped");
        end
        bus_rd(5, c1); chk("R3", c1, c0, "counter holds while stopped");
    endtask

    task automatic t_bad_key_stopped();
        logic [DW-1:0] v;
        bus_wr(3, 32'h0000_BBBB); wait_idle();
        bus_wr(3, 32'h0000_1234); wait_idle();
        bus_wr(3, 32'h0000_4444); wait_idle();
        bus_rd(3, v); chk("R4", v, 32'h0, "broken start pair stays stopped");
    endtask

    task automatic t_prescale();
        logic [DW-1:0] v, c0, c1;
        bus_wr(0, 32'h5); wait_idle();
        bus_rd(0, v); chk("R5", v, 32'h5, "control written while stopped");
        key_pair(32'h0000_BBBB, 32'h0000_4444);
        bus_rd(5, c0);
        repeat (40) @(negedge clk);
        bus_rd(5, c1);
        chk("R5", c1 - c0, 32'd10, "divide by four rate");
        key_pair(32'h0000_AAAA, 32'h0000_5555);
        bus_wr(0, 32'h0); wait_idle();
    endtask

    task automatic t_overflow();
        logic [DW-1:0] v, prev;
        bit seen;
        bus_wr(1, 32'hFFFF_FFF0); wait_idle();
        key_pair(32'h0000_BBBB, 32'h0000_4444);
        seen = 1'b0;
        prev = '0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rst_req) begin seen = 1'b1; break; end
            bus_rd(5, prev);
        end
        chk("R6", DW'(seen), 32'h1, "reset request raised");
        chk("R6", prev, 32'hFFFF_FFFF, "counter at all ones before overflow");
        bus_rd(5, v); chk("R6", v, 32'hFFFF_FFF0, "reloaded on overflow");
        @(negedge clk);
        chk("R6", DW'(rst_req), 32'h0, "request lasts one cycle");
        bus_rd(5, v); chk("R6", v, 32'hFFFF_FFF1, "counting continues");
    endtask

    task automatic t_collision();
        logic [DW-1:0] v;
        bit hit;
        for (int i = 0; i < 40; i++) begin
            bus_rd(5, v);
            if (v == 32'hFFFF_FFFC) break;
            @(negedge clk);
        end
        chk("R11", v, 32'hFFFF_FFFC, "reached trigger point");
        trig_val = ~trig_val;
        bus_wr(2, trig_val);
        hit = rst_req;
        @(negedge clk);
        bus_rd(5, v); chk("R11", v, 32'hFFFF_FFFF, "counter one before overflow");
        hit = hit | rst_req;
        @(negedge clk);
        bus_rd(5, v); chk("R11", v, 32'hFFFF_FFF0, "reload wins over overflow");
        hit = hit | rst_req;
        @(negedge clk);
        hit = hit | rst_req;
        chk("R11", DW'(hit), 32'h0, "no reset request on collision");
        key_pair(32'h0000_AAAA, 32'h0000_5555);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_posting();
        t_start();
        t_rate_plain();
        t_frozen();
        t_trigger();
        t_bad_key_running();
        t_stop();
        t_bad_key_stopped();
        t_prescale();
        t_overflow();
        t_collision();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL all watchdog actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule